// File: doc/BRIEF.md
# I2C Word Transmitter (Bus Master)

This block is the sending half of a serial bus master for a two-wire, open-drain bus. The host loads a data word, picks how many bits the word carries and whether an acknowledge clock follows. The block then sends the word on the data line, driving its own clock line. When the bus is idle, the first word is preceded by a start condition. Between words the block needs no help from software: it pulls the clock low and waits.

When a word finishes, the block pulses an interrupt and drops its service flag to 0. It then keeps SCL low for as long as the host needs. The host reads the bit captured in the last clock to decide what to do next. A 0 means the receiver wants more, so the host writes the next word, which goes out at once with no new start. A 1 means the receiver refuses more data, so the host requests a stop. The block then sends a stop condition and releases both lines.

The two line outputs are pull-down enables: 1 pulls the line low and 0 releases it. The data line's actual level comes back on a separate input. Each SCL high phase and each SCL low phase lasts a number of system clocks taken from a divider input.

Top module: `i2c_word_tx`

## Requirements
- R1: After reset both lines are released, `pending_o` is 1, and `irq_o` and `lrb_o` are 0.
- R2: A write accepted while idle makes a start condition. SDA is pulled low with SCL released for one phase, and then SCL is pulled low.
- R3: `bcnt_i` sets the word length. Code 0 means 8 bits and codes 1 to 7 mean that many bits. The word is the low bits of `wdata_i`, sent most significant bit first. A 0 bit pulls SDA low and a 1 bit releases it.
- R4: During data and stop setup, SDA changes only while SCL is held low, one system clock after SCL fell. SDA never changes in a clock where SCL changes.
- R5: Each SCL phase lasts P system clocks. P is `div_i` sampled when the write or stop is accepted, and values below 2 act as 2.
- R6: With `ack_en_i` set, one extra clock follows the data bits, with SDA released.
- R7: `lrb_o` takes the level of `sda_i` at the rising SCL edge of the last clock of each word. That last clock is the acknowledge clock when it is enabled, and the final data bit otherwise.
- R8: At the end of a word, `irq_o` is high for exactly one clock and `pending_o` goes to 0. SCL then stays low, with no further clock pulses, until the host acts.
- R9: A write accepted while `pending_o` is 0 sends the next word with no start condition. SCL stays low until the first data bit's high phase.
- R10: Writes made while a word or a stop is in progress are ignored. A stop request made while `pending_o` is 1 is ignored, and this includes requests made while idle.
- R11: A stop request accepted while `pending_o` is 0 pulls SDA low during one SCL low phase and then releases SCL for one phase. It then releases SDA, and the bus is idle with `pending_o` equal to 1.
- R12: If a write and a stop request arrive in the same clock while `pending_o` is 0, the write is taken and the stop request is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| div_i | input | DIV_W | SCL phase length in system clocks (minimum 2) |
| wr_i | input | 1 | Host write strobe for the transmit word |
| wdata_i | input | WORD_W | Transmit word |
| bcnt_i | input | BC_W | Bit count code (0 = full word) |
| ack_en_i | input | 1 | Add an acknowledge clock after the data bits |
| stop_i | input | 1 | Host stop request strobe |
| sda_i | input | 1 | Sensed level of the data line |
| scl_oe_o | output | 1 | 1 pulls SCL low |
| sda_oe_o | output | 1 | 1 pulls SDA low |
| pending_o | output | 1 | 0 while waiting for the host between words |
| lrb_o | output | 1 | Line level captured in the last clock of a word |
| irq_o | output | 1 | One-clock pulse at the end of each word |

## Verification
The bench goes after the points where a word meets its neighbours. These are the handover from start to the first bit, the step from one word to the next with no new start, and the step from the acknowledge slot into the stop. A design that changed SDA on the SCL edge itself would create false start or stop conditions on the bus. A design that emitted one more or one fewer clock would misalign every following word. The bench also sends a 1-bit word with a divider of 0, and a full 8-bit word with the acknowledge off. An error in decoding the bit count, or in clamping the divider, would shift the captured last bit or shrink the phases. Writes and stop requests arrive mid-word, in idle, and together in one clock. A block that obeyed any of them at the wrong time would visibly break the line waveform.

// File: rtl/i2cw_pkg.sv
package i2cw_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_LOW,
    ST_HIGH,
    ST_HOLD,
    ST_STP_LOW,
    ST_STP_HIGH
  } state_t;

  localparam int unsigned MIN_PHASE = 2;

endpackage

// File: rtl/i2cw_phase_timer.sv
module i2cw_phase_timer #(
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             next_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             first_o,
  output logic             last_o
);

  localparam logic [DIV_W-1:0] MINP = DIV_W'(i2cw_pkg::MIN_PHASE);

  logic [DIV_W-1:0] per_q, per_nxt, per_eff;
  logic [DIV_W-1:0] cnt_q, cnt_nxt;
  logic             per_en, cnt_en;

  always_comb begin
    per_eff = (div_i < MINP) ? MINP : div_i;
    per_en  = start_i;
    per_nxt = per_eff;
    cnt_en  = start_i | next_i | (cnt_q != '0);
    if (start_i)
      cnt_nxt = per_eff - DIV_W'(1);
    else if (next_i)
      cnt_nxt = per_q - DIV_W'(1);
    else
      cnt_nxt = cnt_q - DIV_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      per_q <= MINP;
      cnt_q <= '0;
    end else begin
      if (per_en) per_q <= per_nxt;
      if (cnt_en) cnt_q <= cnt_nxt;
    end
  end

  assign first_o = (cnt_q == per_q - DIV_W'(1));
  assign last_o  = (cnt_q == '0);

endmodule

// File: rtl/i2cw_shifter.sv
module i2cw_shifter #(
  parameter int unsigned WORD_W = 8,
  parameter int unsigned BC_W   = $clog2(WORD_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [WORD_W-1:0] data_i,
  input  logic [BC_W-1:0]   code_i,
  input  logic              ack_en_i,
  input  logic              adv_i,
  output logic              level_o,
  output logic              final_o
);

  localparam int unsigned SL_W = $clog2(WORD_W + 2);

  logic [WORD_W-1:0] sh_q, sh_nxt;
  logic [SL_W-1:0]   left_q, left_nxt, len, shamt;
  logic              ack_q, ack_nxt;
  logic              upd_en;

  always_comb begin
    len      = (code_i == '0) ? SL_W'(WORD_W) : SL_W'(code_i);
    shamt    = SL_W'(WORD_W) - len;
    upd_en   = load_i | adv_i;
    sh_nxt   = sh_q;
    left_nxt = left_q;
    ack_nxt  = ack_q;
    if (load_i) begin
      sh_nxt   = data_i << shamt;
      left_nxt = len + SL_W'(ack_en_i);
      ack_nxt  = ack_en_i;
    end else if (adv_i) begin
      sh_nxt   = sh_q << 1;
      left_nxt = left_q - SL_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      left_q <= '0;
      ack_q  <= 1'b0;
    end else if (upd_en) begin
      sh_q   <= sh_nxt;
      left_q <= left_nxt;
      ack_q  <= ack_nxt;
    end
  end

  assign final_o = (left_q == SL_W'(1));
  assign level_o = (final_o && ack_q) ? 1'b1 : sh_q[WORD_W-1];

endmodule

// File: rtl/i2c_word_tx.sv
module i2c_word_tx #(
  parameter int unsigned DIV_W  = 8,
  parameter int unsigned WORD_W = 8,
  parameter int unsigned BC_W   = $clog2(WORD_W),
  parameter int unsigned SYNC_N = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DIV_W-1:0]  div_i,
  input  logic              wr_i,
  input  logic [WORD_W-1:0] wdata_i,
  input  logic [BC_W-1:0]   bcnt_i,
  input  logic              ack_en_i,
  input  logic              stop_i,
  input  logic              sda_i,
  output logic              scl_oe_o,
  output logic              sda_oe_o,
  output logic              pending_o,
  output logic              lrb_o,
  output logic              irq_o
);

  import i2cw_pkg::*;

  // reset: asserted asynchronously, released on a clock edge
  logic [SYNC_N-1:0] rsync_q;
  logic              rst_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= '0;
    else        rsync_q <= {rsync_q[SYNC_N-2:0], 1'b1};
  end
  assign rst_q = rsync_q[SYNC_N-1];

  state_t st_q, st_nxt;
  logic   scl_q, scl_nxt, sda_q, sda_nxt, pin_q, pin_nxt;
  logic   irq_q, irq_nxt, lrb_q, lrb_en;
  logic   t_start, t_next, t_first, t_last;
  logic   sh_load, sh_adv, sh_level, sh_final;

  i2cw_phase_timer #(.DIV_W(DIV_W)) u_timer (
    .clk     (clk),
    .rst_n   (rst_q),
    .start_i (t_start),
    .next_i  (t_next),
    .div_i   (div_i),
    .first_o (t_first),
    .last_o  (t_last)
  );

  i2cw_shifter #(.WORD_W(WORD_W), .BC_W(BC_W)) u_shift (
    .clk      (clk),
    .rst_n    (rst_q),
    .load_i   (sh_load),
    .data_i   (wdata_i),
    .code_i   (bcnt_i),
    .ack_en_i (ack_en_i),
    .adv_i    (sh_adv),
    .level_o  (sh_level),
    .final_o  (sh_final)
  );

  always_comb begin
    st_nxt  = st_q;
    t_start = 1'b0;
    t_next  = 1'b0;
    sh_load = 1'b0;
    sh_adv  = 1'b0;
    sda_nxt = sda_q;
    lrb_en  = 1'b0;
    irq_nxt = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (wr_i) begin
          st_nxt  = ST_START;
          t_start = 1'b1;
          sh_load = 1'b1;
          sda_nxt = 1'b1;
        end
      end
      ST_START: begin
        if (t_last) begin
          st_nxt = ST_LOW;
          t_next = 1'b1;
        end
      end
      ST_LOW: begin
        if (t_first) sda_nxt = ~sh_level;
        if (t_last) begin
          st_nxt = ST_HIGH;
          t_next = 1'b1;
          lrb_en = sh_final;
        end
      end
      ST_HIGH: begin
        if (t_last) begin
          if (sh_final) begin
            st_nxt  = ST_HOLD;
            irq_nxt = 1'b1;
          end else begin
            st_nxt = ST_LOW;
            t_next = 1'b1;
            sh_adv = 1'b1;
          end
        end
      end
      ST_HOLD: begin
        if (wr_i) begin
          st_nxt  = ST_LOW;
          t_start = 1'b1;
          sh_load = 1'b1;
        end else if (stop_i) begin
          st_nxt  = ST_STP_LOW;
          t_start = 1'b1;
        end
      end
      ST_STP_LOW: begin
        if (t_first) sda_nxt = 1'b1;
        if (t_last) begin
          st_nxt = ST_STP_HIGH;
          t_next = 1'b1;
        end
      end
      ST_STP_HIGH: begin
        if (t_last) begin
          st_nxt  = ST_IDLE;
          sda_nxt = 1'b0;
        end
      end
      default: st_nxt = ST_IDLE;
    endcase
    scl_nxt = (st_nxt == ST_LOW) || (st_nxt == ST_HOLD) || (st_nxt == ST_STP_LOW);
    pin_nxt = (st_nxt != ST_HOLD);
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      st_q  <= ST_IDLE;
      scl_q <= 1'b0;
      sda_q <= 1'b0;
      pin_q <= 1'b1;
      irq_q <= 1'b0;
      lrb_q <= 1'b0;
    end else begin
      st_q  <= st_nxt;
      scl_q <= scl_nxt;
      sda_q <= sda_nxt;
      pin_q <= pin_nxt;
      irq_q <= irq_nxt;
      if (lrb_en) lrb_q <= sda_i;
    end
  end

  assign scl_oe_o  = scl_q;
  assign sda_oe_o  = sda_q;
  assign pending_o = pin_q;
  assign irq_o     = irq_q;
  assign lrb_o     = lrb_q;

endmodule

// File: rtl/i2cw_chk.sv
module i2cw_chk (
  input logic clk,
  input logic rst_n,
  input logic scl_oe,
  input logic sda_oe,
  input logic pin,
  input logic irq,
  input logic lrb,
  input logic idle
);

  // R8
  hold_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pin |-> scl_oe);

  // R8
  irq_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);

  // R8
  irq_in_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (!pin && scl_oe));

  // R4
  sda_at_scl_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(scl_oe) |-> $stable(sda_oe));

  // R4
  sda_at_scl_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(scl_oe) |-> $stable(sda_oe));

  // R7
  lrb_on_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(lrb) |-> $fell(scl_oe));

  // R2
  start_from_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(sda_oe) && !scl_oe) |-> $past(idle));

  // R11
  idle_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
    idle |-> (!scl_oe && !sda_oe && pin));

endmodule

bind i2c_word_tx i2cw_chk u_chk (
  .clk    (clk),
  .rst_n  (rst_q),
  .scl_oe (scl_oe_o),
  .sda_oe (sda_oe_o),
  .pin    (pending_o),
  .irq    (irq_o),
  .lrb    (lrb_o),
  .idle   (st_q == i2cw_pkg::ST_IDLE)
);

// File: tb/tb_i2c_word_tx.sv
`timescale 1ns/1ps
module tb_i2c_word_tx;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] div_i = 8'd2;
  logic       wr_i = 1'b0, stop_i = 1'b0, ack_en_i = 1'b0;
  logic [7:0] wdata_i = '0;
  logic [2:0] bcnt_i = '0;
  logic       ack_drive = 1'b0;
  logic       sda_line;
  logic       scl_oe_o, sda_oe_o, pending_o, lrb_o, irq_o;

  always #2.5 clk = ~clk;

  assign sda_line = !sda_oe_o && !ack_drive;

  i2c_word_tx dut (
    .clk(clk), .rst_n(rst_n), .div_i(div_i), .wr_i(wr_i), .wdata_i(wdata_i),
    .bcnt_i(bcnt_i), .ack_en_i(ack_en_i), .stop_i(stop_i), .sda_i(sda_line),
    .scl_oe_o(scl_oe_o), .sda_oe_o(sda_oe_o), .pending_o(pending_o),
    .lrb_o(lrb_o), .irq_o(irq_o)
  );

  int errs = 0, checks = 0;
  logic [4:0] q[$];            // {scl, sda, pin, irq, lrb}
  logic [4:0] steady = 5'b00100;
  int   mode = 0;              // 0 idle, 1 waiting for host
  logic cur_sda = 1'b0, cur_lrb = 1'b0;
  bit   run_chk = 0, done = 0;
  logic p_scl = 1'b0, p_sda = 1'b0;

  task automatic chk(input bit ok, input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic string tag_of(input logic [4:0] a, input logic [4:0] e);
    if (a[4] !== e[4]) return "R5 scl timing";
    if (a[3] !== e[3]) return "R3/R6 sda data";
    if (a[2] !== e[2]) return "R8 pending flag";
    if (a[1] !== e[1]) return "R8 irq pulse";
    return "R7 last bit";
  endfunction

  task automatic push(input logic c, input logic d, input logic p, input logic i, input logic l);
    q.push_back({c, d, p, i, l});
  endtask

  task automatic push_word(input logic [7:0] data, input logic [2:0] bits, input logic ack,
                           input logic [7:0] div, input bit from_idle, input logic adrv);
    int p = (div < 2) ? 2 : int'(div);
    int n = (bits == 0) ? 8 : int'(bits);
    int slots = n + int'(ack);
    logic prev = from_idle ? 1'b1 : cur_sda;
    logic lnew = ack ? !adrv : data[0];
    if (from_idle) repeat (p) push(1'b0, 1'b1, 1'b1, 1'b0, cur_lrb);
    for (int s = 0; s < slots; s++) begin
      logic oe = (s < n) ? !data[n-1-s] : 1'b0;
      push(1'b1, prev, 1'b1, 1'b0, cur_lrb);
      repeat (p-1) push(1'b1, oe, 1'b1, 1'b0, cur_lrb);
      if (s == slots-1) cur_lrb = lnew;
      repeat (p) push(1'b0, oe, 1'b1, 1'b0, cur_lrb);
      prev = oe;
    end
    push(1'b1, prev, 1'b0, 1'b1, cur_lrb);
    cur_sda = prev;
    steady = {1'b1, prev, 1'b0, 1'b0, cur_lrb};
  endtask

  task automatic push_stop(input logic [7:0] div);
    int p = (div < 2) ? 2 : int'(div);
    push(1'b1, cur_sda, 1'b1, 1'b0, cur_lrb);
    repeat (p-1) push(1'b1, 1'b1, 1'b1, 1'b0, cur_lrb);
    repeat (p) push(1'b0, 1'b1, 1'b1, 1'b0, cur_lrb);
    cur_sda = 1'b0;
    steady = {1'b0, 1'b0, 1'b1, 1'b0, cur_lrb};
  endtask

  // per-cycle comparison against the reference model
  always @(negedge clk) begin
    if (run_chk) begin
      logic [4:0] e;
      logic [4:0] a;
      e = (q.size() != 0) ? q.pop_front() : steady;
      a = {scl_oe_o, sda_oe_o, pending_o, irq_o, lrb_o};
      chk(a === e, tag_of(a, e), {3'b0, a}, {3'b0, e});
      if (sda_oe_o !== p_sda)
        chk(scl_oe_o === p_scl, "R4 sda moved with scl", {7'b0, scl_oe_o}, {7'b0, p_scl});
      p_scl = scl_oe_o;
      p_sda = sda_oe_o;
    end
  end

  task automatic do_cmd(input logic w, input logic s, input logic [7:0] data, input logic [2:0] bits,
                        input logic ack, input logic [7:0] div, input logic adrv);
    @(negedge clk);
    wr_i = w; stop_i = s; wdata_i = data; bcnt_i = bits; ack_en_i = ack; div_i = div;
    @(posedge clk);
    #1;
    wr_i = 1'b0; stop_i = 1'b0;
    if (q.size() == 0 && w) begin
      ack_drive = adrv;
      push_word(data, bits, ack, div, mode == 0, adrv);
      mode = 1;
    end else if (q.size() == 0 && s && mode == 1) begin
      push_stop(div);
      mode = 0;
    end
  endtask

  task automatic wait_q();
    while (q.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    run_chk = 1;
    @(negedge clk);
    chk(!scl_oe_o && !sda_oe_o && pending_o && !irq_o && !lrb_o, "R1 reset state",
        {3'b0, scl_oe_o, sda_oe_o, pending_o, irq_o, lrb_o}, 8'h04);

    // full word with acknowledge, receiver pulls low
    do_cmd(1'b1, 1'b0, 8'hA5, 3'd0, 1'b1, 8'd3, 1'b1);
    @(negedge clk);
    chk(sda_oe_o && !scl_oe_o, "R2 start condition", {6'b0, scl_oe_o, sda_oe_o}, 8'h01);
    wait_q();
    chk(lrb_o == 1'b0, "R7 ack captured", {7'b0, lrb_o}, 8'h00);
    repeat (15) @(negedge clk);
    chk(!pending_o && scl_oe_o, "R8 scl held while waiting", {6'b0, pending_o, scl_oe_o}, 8'h01);

    // next word from the wait state, receiver refuses
    do_cmd(1'b1, 1'b0, 8'h05, 3'd3, 1'b1, 8'd2, 1'b0);
    @(negedge clk);
    chk(scl_oe_o == 1'b1, "R9 no start between words", {7'b0, scl_oe_o}, 8'h01);
    wait_q();
    chk(lrb_o == 1'b1, "R7 nack captured", {7'b0, lrb_o}, 8'h01);

    // 1-bit word, divider 0 clamps; writes and stops mid-word are ignored
    do_cmd(1'b1, 1'b0, 8'h01, 3'd1, 1'b0, 8'd0, 1'b0);
    repeat (2) @(negedge clk);
    do_cmd(1'b1, 1'b0, 8'hFF, 3'd0, 1'b1, 8'd5, 1'b0);
    do_cmd(1'b0, 1'b1, 8'h00, 3'd0, 1'b0, 8'd5, 1'b0);
    wait_q();
    chk(lrb_o == 1'b1, "R7 last data bit", {7'b0, lrb_o}, 8'h01);
    chk(pending_o == 1'b0, "R10 busy stop ignored", {7'b0, pending_o}, 8'h00);

    // stop condition
    do_cmd(1'b0, 1'b1, 8'h00, 3'd0, 1'b0, 8'd4, 1'b0);
    wait_q();
    chk(!scl_oe_o && !sda_oe_o && pending_o, "R11 bus idle after stop",
        {5'b0, scl_oe_o, sda_oe_o, pending_o}, 8'h01);

    // stop in idle is ignored
    do_cmd(1'b0, 1'b1, 8'h00, 3'd0, 1'b0, 8'd3, 1'b0);
    repeat (5) @(negedge clk);
    chk(!scl_oe_o && !sda_oe_o, "R10 idle stop ignored", {6'b0, scl_oe_o, sda_oe_o}, 8'h00);

    // 6-bit word; divider changes mid-word must not matter
    do_cmd(1'b1, 1'b0, 8'h3C, 3'd6, 1'b0, 8'd5, 1'b0);
    repeat (4) @(negedge clk);
    div_i = 8'd9;
    wait_q();
    chk(lrb_o == 1'b0, "R7 R5 six-bit word end", {7'b0, lrb_o}, 8'h00);

    // write and stop together: write wins
    do_cmd(1'b1, 1'b1, 8'h02, 3'd2, 1'b1, 8'd3, 1'b1);
    wait_q();
    chk(pending_o == 1'b0, "R12 write over stop", {7'b0, pending_o}, 8'h00);

    // full 8-bit word without acknowledge
    do_cmd(1'b1, 1'b0, 8'h81, 3'd0, 1'b0, 8'd2, 1'b0);
    wait_q();
    chk(lrb_o == 1'b1, "R3 eight-bit last bit", {7'b0, lrb_o}, 8'h01);

    do_cmd(1'b0, 1'b1, 8'h00, 3'd0, 1'b0, 8'd2, 1'b0);
    wait_q();
    repeat (3) @(negedge clk);
    run_chk = 0;
    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    #900000;
    if (!done) begin
      checks++;
      errs++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

endmodule